// File: doc/BRIEF.md
# CMAC Sequencer with Truncated Tag Check

This block drives AES-CMAC authentication of a message through an external 128-bit block-cipher engine. The engine holds the key and applies it. The sequencer sends one block per request and takes one block back per response. Software loads the six 64-bit context registers and programs the mode. It then streams 128-bit data blocks and writes the end-of-message register. The block chains the blocks, derives the two subkeys from the encryption of the zero block, applies the final-block rule, and leaves the MAC in context registers 1–2.

One block is always held back so the final block is known when end-of-message arrives. A message can be cut into parts. A part run with the suspend bit set leaves the running chaining value in registers 1–2, and the subkey value is always kept in registers 5–6. Software can save both and reload them later, then continue. With the check bit set, the leading bytes of the computed MAC are compared with a received MAC held in registers 3–4. The outcome appears in the status register.

Top module: `cmac_seq`

## Requirements
- R1: After reset, context registers 1–6 read 0, the ICV length reads 16, the final-size register reads 16, the mode reads 0, status reads 0 and `busy_o` is low.
- R2: Every data block except the one held at end-of-message is chained as X = E(X xor M). X starts from context registers 1–2 (register 1 is bits 127:64) and its new value is written back there.
- R3: With reuse (mode bit 2) clear, end-of-message first sends the all-zero block to the engine and stores the result in context registers 5–6.
- R4: With reuse set, no zero-block cipher pass is made and registers 5–6 are used as given. K1 is that value shifted left one bit, xored with 0x87 when the bit shifted out is 1, and K2 is K1 treated the same way.
- R5: With suspend (mode bit 1) clear and a final size of 16 or more, the held block is xored with K1 and then chained. The result is the MAC in registers 1–2.
- R6: With a final size n below 16, the held block keeps bytes 0..n-1 (byte 0 is bits 127:120), byte n becomes 0x80 and the later bytes become 0. The block is then xored with K2 and chained. With no block held, the padded empty block is used.
- R7: With suspend set, the held block is chained as an ordinary block and no subkey is applied. The chaining value is left in registers 1–2, so resuming with suspend clear gives the MAC of the whole message.
- R8: With check (mode bit 3) set and suspend clear, the first ICV-length bytes of {reg1,reg2} are compared with {reg3,reg4}. Status bit 1 is set on a match and status bit 2 on a mismatch.
- R9: Only ICV-length writes of 8, 10, 12, 14 or 16 are taken; other values are ignored. With suspend set, no check is made and status bits 1–2 stay 0.
- R10: Mode bit 0 (direction) has no effect on the result.
- R11: `busy_o` rises on the cycle after end-of-message is written and falls when the MAC and status are valid. While the block is not idle, `blk_ready_o` is low and register writes are ignored.
- R12: Register word addresses: 0 mode, 1 ICV length, 2 final size in bytes, 3 end-of-message (write only), 4 status (bit 0 busy), 8 to 13 context registers 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| blk_valid_i | input | 1 | Data block offered |
| blk_i | input | 128 | Data block |
| blk_ready_o | output | 1 | Data block accepted this cycle when valid |
| eng_req_o | output | 1 | One-cycle cipher request |
| eng_blk_o | output | 128 | Block to encrypt |
| eng_rsp_valid_i | input | 1 | Cipher result valid |
| eng_rsp_i | input | 128 | Cipher result |
| busy_o | output | 1 | Final MAC in progress |

## Verification
The bench builds the block with its default parameters: a 4-bit register address and the package's 64-bit context and 128-bit block widths. At these widths the ICV lengths from 8 to 16 bytes and the padding positions 0 to 15 can all be reached. A stand-in cipher with a three-cycle response lets the bench count engine requests. That count shows whether the zero-block pass was skipped. Mismatches are placed at bytes on either side of a truncated ICV length.

// File: rtl/cmac_seq_pkg.sv
package cmac_seq_pkg;
  localparam int unsigned CTX_W   = 64;
  localparam int unsigned BLK_W   = 2 * CTX_W;
  localparam int unsigned NBYTES  = BLK_W / 8;
  localparam int unsigned LEN_W   = $clog2(NBYTES) + 1;
  localparam int unsigned NCTX    = 6;
  localparam int unsigned MIN_ICV = 8;

  localparam int unsigned A_MODE = 0;
  localparam int unsigned A_ICV  = 1;
  localparam int unsigned A_SIZE = 2;
  localparam int unsigned A_EOM  = 3;
  localparam int unsigned A_STAT = 4;
  localparam int unsigned A_CTX0 = 8;

  localparam logic [BLK_W-1:0] RB_POLY = BLK_W'(8'h87);

  typedef enum logic [3:0] {
    S_IDLE, S_CH_REQ, S_CH_WAIT, S_L_REQ, S_L_WAIT,
    S_F_PREP, S_F_REQ, S_F_WAIT, S_CHECK
  } state_e;

  function automatic logic [BLK_W-1:0] gf_dbl(input logic [BLK_W-1:0] v);
    return {v[BLK_W-2:0], 1'b0} ^ (v[BLK_W-1] ? RB_POLY : '0);
  endfunction

  function automatic logic icv_legal(input logic [LEN_W-1:0] v);
    return (v >= LEN_W'(MIN_ICV)) && (v <= LEN_W'(NBYTES)) && !v[0];
  endfunction
endpackage

// File: rtl/cmac_subkey.sv
module cmac_subkey import cmac_seq_pkg::*; (
  input  logic [BLK_W-1:0] l_i,
  output logic [BLK_W-1:0] k1_o,
  output logic [BLK_W-1:0] k2_o
);
  assign k1_o = gf_dbl(l_i);
  assign k2_o = gf_dbl(k1_o);
endmodule

// File: rtl/cmac_final_fmt.sv
module cmac_final_fmt import cmac_seq_pkg::*; (
  input  logic [BLK_W-1:0] blk_i,
  input  logic [LEN_W-1:0] nbytes_i,
  input  logic [BLK_W-1:0] k1_i,
  input  logic [BLK_W-1:0] k2_i,
  output logic [BLK_W-1:0] blk_o
);
  logic [BLK_W-1:0] padded;
  logic             full;

  assign full = nbytes_i >= LEN_W'(NBYTES);

  // byte 0 sits at the top of the block
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int unsigned HI = BLK_W - 1 - 8 * i;
    assign padded[HI -: 8] = (LEN_W'(i) < nbytes_i)  ? blk_i[HI -: 8] :
                             (LEN_W'(i) == nbytes_i) ? 8'h80 : 8'h00;
  end

  assign blk_o = full ? (blk_i ^ k1_i) : (padded ^ k2_i);
endmodule

// File: rtl/cmac_icv_cmp.sv
module cmac_icv_cmp import cmac_seq_pkg::*; (
  input  logic [BLK_W-1:0] mac_i,
  input  logic [BLK_W-1:0] ref_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             match_o
);
  logic [NBYTES-1:0] ok;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int unsigned HI = BLK_W - 1 - 8 * i;
    assign ok[i] = (LEN_W'(i) >= len_i) || (mac_i[HI -: 8] == ref_i[HI -: 8]);
  end

  assign match_o = &ok;
endmodule

// File: rtl/cmac_seq.sv
module cmac_seq import cmac_seq_pkg::*; #(
  parameter int unsigned AW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [CTX_W-1:0] reg_wdata_i,
  output logic [CTX_W-1:0] reg_rdata_o,
  input  logic             blk_valid_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             blk_ready_o,
  output logic             eng_req_o,
  output logic [BLK_W-1:0] eng_blk_o,
  input  logic             eng_rsp_valid_i,
  input  logic [BLK_W-1:0] eng_rsp_i,
  output logic             busy_o
);
  state_e           st_q;
  logic [CTX_W-1:0] ctx_q [NCTX];
  logic             dir_q, aux0_q, aux1_q, aux2_q;
  logic [LEN_W-1:0] icv_len_q, last_n_q;
  logic             busy_q, pass_q, fail_q;
  logic [BLK_W-1:0] held_q, ci_q;
  logic             held_vld_q;

  logic [BLK_W-1:0] chain_w, rx_w, l_w, k1_w, k2_w, fin_w;
  logic             match_w, wr_ok, eom_w;

  assign chain_w = {ctx_q[0], ctx_q[1]};
  assign rx_w    = {ctx_q[2], ctx_q[3]};
  assign l_w     = {ctx_q[4], ctx_q[5]};

  cmac_subkey u_subkey (.l_i(l_w), .k1_o(k1_w), .k2_o(k2_w));

  cmac_final_fmt u_fmt (
    .blk_i(held_q), .nbytes_i(held_vld_q ? last_n_q : '0),
    .k1_i(k1_w), .k2_i(k2_w), .blk_o(fin_w)
  );

  cmac_icv_cmp u_icv (.mac_i(chain_w), .ref_i(rx_w), .len_i(icv_len_q), .match_o(match_w));

  assign wr_ok       = reg_we_i && (st_q == S_IDLE);
  assign eom_w       = wr_ok && (reg_addr_i == AW'(A_EOM));
  assign blk_ready_o = (st_q == S_IDLE) && !eom_w;
  assign eng_req_o   = (st_q == S_CH_REQ) || (st_q == S_L_REQ) || (st_q == S_F_REQ);
  assign eng_blk_o   = ci_q;
  assign busy_o      = busy_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(A_MODE))      reg_rdata_o = CTX_W'({aux2_q, aux1_q, aux0_q, dir_q});
    else if (reg_addr_i == AW'(A_ICV))  reg_rdata_o = CTX_W'(icv_len_q);
    else if (reg_addr_i == AW'(A_SIZE)) reg_rdata_o = CTX_W'(last_n_q);
    else if (reg_addr_i == AW'(A_STAT)) reg_rdata_o = CTX_W'({fail_q, pass_q, busy_q});
    for (int i = 0; i < NCTX; i++)
      if (reg_addr_i == AW'(A_CTX0 + i)) reg_rdata_o = ctx_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      for (int i = 0; i < NCTX; i++) ctx_q[i] <= '0;
      dir_q      <= 1'b0;
      aux0_q     <= 1'b0;
      aux1_q     <= 1'b0;
      aux2_q     <= 1'b0;
      icv_len_q  <= LEN_W'(NBYTES);
      last_n_q   <= LEN_W'(NBYTES);
      busy_q     <= 1'b0;
      pass_q     <= 1'b0;
      fail_q     <= 1'b0;
      held_q     <= '0;
      ci_q       <= '0;
      held_vld_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        if (reg_addr_i == AW'(A_MODE))
          {aux2_q, aux1_q, aux0_q, dir_q} <= reg_wdata_i[3:0];
        if (reg_addr_i == AW'(A_ICV) && icv_legal(reg_wdata_i[LEN_W-1:0]) &&
            (reg_wdata_i[CTX_W-1:LEN_W] == '0))
          icv_len_q <= reg_wdata_i[LEN_W-1:0];
        if (reg_addr_i == AW'(A_SIZE))
          last_n_q <= reg_wdata_i[LEN_W-1:0];
        for (int i = 0; i < NCTX; i++)
          if (reg_addr_i == AW'(A_CTX0 + i)) ctx_q[i] <= reg_wdata_i;
      end
      unique case (st_q)
        S_IDLE: begin
          if (eom_w) begin
            busy_q <= 1'b1;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            ci_q   <= '0;
            st_q   <= aux1_q ? S_F_PREP : S_L_REQ;
          end else if (blk_valid_i) begin
            held_q     <= blk_i;
            held_vld_q <= 1'b1;
            if (held_vld_q) begin
              ci_q <= held_q ^ chain_w;
              st_q <= S_CH_REQ;
            end
          end
        end
        S_CH_REQ: st_q <= S_CH_WAIT;
        S_CH_WAIT: if (eng_rsp_valid_i) begin
          {ctx_q[0], ctx_q[1]} <= eng_rsp_i;
          st_q <= S_IDLE;
        end
        S_L_REQ: st_q <= S_L_WAIT;
        S_L_WAIT: if (eng_rsp_valid_i) begin
          {ctx_q[4], ctx_q[5]} <= eng_rsp_i;
          st_q <= S_F_PREP;
        end
        S_F_PREP: begin
          held_vld_q <= 1'b0;
          if (aux0_q) begin
            ci_q <= held_q ^ chain_w;
            st_q <= held_vld_q ? S_F_REQ : S_CHECK;
          end else begin
            ci_q <= fin_w ^ chain_w;
            st_q <= S_F_REQ;
          end
        end
        S_F_REQ: st_q <= S_F_WAIT;
        S_F_WAIT: if (eng_rsp_valid_i) begin
          {ctx_q[0], ctx_q[1]} <= eng_rsp_i;
          st_q <= S_CHECK;
        end
        S_CHECK: begin
          busy_q <= 1'b0;
          if (aux2_q && !aux0_q) begin
            pass_q <= match_w;
            fail_q <= !match_w;
          end
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmac_seq_chk.sv
module cmac_seq_chk import cmac_seq_pkg::*; #(
  parameter int unsigned AW = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [AW-1:0]    reg_addr_i,
  input logic             blk_ready_o,
  input logic             eng_req_o,
  input logic             busy_o,
  input logic [LEN_W-1:0] icv_len_i,
  input logic             pass_i,
  input logic             fail_i
);
  a_r11_busy_after_eom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(reg_we_i && reg_addr_i == AW'(A_EOM)));

  a_r11_no_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !blk_ready_o);

  a_r2_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o |=> !eng_req_o);

  a_r9_icv_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icv_legal(icv_len_i));

  a_r8_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_i && fail_i));

  a_r8_status_stable_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(pass_i) && $stable(fail_i)));
endmodule

bind cmac_seq cmac_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .blk_ready_o(blk_ready_o), .eng_req_o(eng_req_o), .busy_o(busy_o),
  .icv_len_i(icv_len_q), .pass_i(pass_q), .fail_i(fail_q)
);

// File: tb/cmac_seq_bench.sv
module cmac_seq_bench;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic         we = 0;
  logic [3:0]   addr = 0;
  logic [63:0]  wdata = 0, rdata;
  logic         bvalid = 0, bready;
  logic [127:0] blk = 0;
  logic         req, rsp_valid = 0, busy;
  logic [127:0] req_blk, rsp = 0;

  cmac_seq u_cmac_seq (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .blk_valid_i(bvalid), .blk_i(blk), .blk_ready_o(bready),
    .eng_req_o(req), .eng_blk_o(req_blk), .eng_rsp_valid_i(rsp_valid), .eng_rsp_i(rsp),
    .busy_o(busy)
  );

  int checks = 0, fails = 0, eng_cnt = 0;
  logic [127:0] msg [8];

  function automatic logic [127:0] fe(input logic [127:0] x);
    logic [127:0] r;
    r = {x[100:0], x[127:101]} ^ 128'h3c6e_f372_a54f_f53a_510e_527f_9b05_688c;
    r[63:0] = r[63:0] + x[127:64];
    return r;
  endfunction

  function automatic logic [127:0] dbl(input logic [127:0] v);
    logic [127:0] r;
    r = v << 1;
    if (v[127]) r[7:0] = r[7:0] ^ 8'h87;
    return r;
  endfunction

  function automatic logic [127:0] pad(input logic [127:0] b, input int n);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < n) r[127-8*i -: 8] = b[127-8*i -: 8];
      else if (i == n) r[127-8*i -: 8] = 8'h80;
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_mac(input int nb, input int lb,
      input logic [127:0] x0, input logic [127:0] l);
    logic [127:0] x = x0, k1, k2, f;
    k1 = dbl(l); k2 = dbl(k1);
    for (int i = 0; i < nb - 1; i++) x = fe(x ^ msg[i]);
    if (nb == 0) f = pad('0, 0) ^ k2;
    else if (lb >= 16) f = msg[nb-1] ^ k1;
    else f = pad(msg[nb-1], lb) ^ k2;
    return fe(x ^ f);
  endfunction

  function automatic logic [127:0] ref_part(input int nb, input logic [127:0] x0);
    logic [127:0] x = x0;
    for (int i = 0; i < nb; i++) x = fe(x ^ msg[i]);
    return x;
  endfunction

  // stand-in cipher, three-cycle response
  logic         pend = 0;
  int           lat = 0;
  logic [127:0] pin = 0;
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (req) begin
      pend <= 1'b1; lat <= 2; pin <= req_blk; eng_cnt <= eng_cnt + 1;
    end else if (pend) begin
      if (lat == 0) begin rsp_valid <= 1'b1; rsp <= fe(pin); pend <= 1'b0; end
      else lat <= lat - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (!bready && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    we = 1; addr = 4'(a); wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    addr = 4'(a); #0.5; d = rdata;
  endtask

  task automatic rd128(input int a, output logic [127:0] d);
    logic [63:0] h, l;
    rd(a, h); rd(a + 1, l); d = {h, l};
  endtask

  task automatic send(input logic [127:0] b);
    wait_idle();
    bvalid = 1; blk = b;
    @(negedge clk);
    bvalid = 0;
  endtask

  task automatic eom();
    int n = 0;
    wait_idle();
    wr(3, 0);
    chk(busy === 1'b1, "R11 busy after eom", 128'(busy), 1);
    while (busy && n < 200) begin @(negedge clk); n++; end
    chk(busy === 1'b0, "R11 busy falls", 128'(busy), 0);
  endtask

  task automatic setup(input int mode, input int lb, input logic [127:0] x0);
    wait_idle();
    wr(0, 64'(mode)); wr(2, 64'(lb));
    wr(8, x0[127:64]); wr(9, x0[63:0]);
  endtask

  task automatic run(input int nb);
    for (int i = 0; i < nb; i++) send(msg[i]);
    eom();
  endtask

  task automatic t_reset();
    logic [63:0] d;
    for (int i = 8; i < 14; i++) begin rd(i, d); chk(d == 0, "R1 ctx reset", 128'(d), 0); end
    rd(1, d); chk(d == 16, "R1 icv reset", 128'(d), 16);
    rd(2, d); chk(d == 16, "R1 size reset", 128'(d), 16);
    rd(0, d); chk(d == 0, "R1 mode reset", 128'(d), 0);
    rd(4, d); chk(d == 0 && busy == 0, "R1 status reset", 128'(d), 0);
  endtask

  task automatic t_full();
    logic [127:0] m, l, e;
    setup(0, 16, 0);
    run(3);
    rd128(12, l); chk(l == fe(0), "R3 zero-block in ctx5-6", l, fe(0));
    e = ref_mac(3, 16, 0, fe(0));
    rd128(8, m); chk(m == e, "R5 complete final", m, e);
    chk(ref_part(2, 0) != 0, "R2 chain nonzero", ref_part(2, 0), 0);
    setup(1, 16, 0);  // R10 direction bit set
    run(3);
    rd128(8, m); chk(m == e, "R10 direction ignored", m, e);
  endtask

  task automatic t_partial_final();
    logic [127:0] m, e;
    setup(0, 5, 0);
    run(2);
    e = ref_mac(2, 5, 0, fe(0));
    rd128(8, m); chk(m == e, "R6 padded final n=5", m, e);
    setup(0, 0, 0);
    eom();
    e = ref_mac(0, 0, 0, fe(0));
    rd128(8, m); chk(m == e, "R6 empty message", m, e);
    setup(0, 15, 0);
    run(1);
    e = ref_mac(1, 15, 0, fe(0));
    rd128(8, m); chk(m == e, "R6 padded final n=15", m, e);
  endtask

  task automatic t_reuse();
    logic [127:0] m, e, lx, l2;
    int c0;
    lx = 128'hf00d_0000_1111_2222_3333_4444_5555_6667;
    setup(4, 16, 0);
    wr(12, lx[127:64]); wr(13, lx[63:0]);
    c0 = eng_cnt;
    run(2);
    e = ref_mac(2, 16, 0, lx);
    rd128(8, m); chk(m == e, "R4 subkeys from loaded value", m, e);
    chk(eng_cnt - c0 == 2, "R4 no zero-block pass", 128'(eng_cnt - c0), 2);
    rd128(12, l2); chk(l2 == lx, "R4 ctx5-6 kept", l2, lx);
  endtask

  task automatic t_suspend();
    logic [127:0] m, e, p;
    logic [63:0] s;
    wait_idle();
    wr(1, 8);
    setup(2 | 8, 16, 0);  // suspend + check
    run(2);
    p = ref_part(2, 0);
    rd128(8, m); chk(m == p, "R7 chain value left", m, p);
    rd(4, s); chk(s == 0, "R9 no check when suspended", 128'(s), 0);
    wait_idle();
    wr(0, 0); wr(2, 16);
    for (int i = 0; i < 2; i++) send(msg[i + 2]);
    eom();
    e = ref_mac(4, 16, 0, fe(0));
    rd128(8, m); chk(m == e, "R7 resume equals whole", m, e);
    wr(1, 16);
  endtask

  task automatic t_icv();
    logic [127:0] e, rx;
    logic [63:0] s;
    e = ref_mac(2, 16, 0, fe(0));
    setup(8, 16, 0);
    wr(10, e[127:64]); wr(11, e[63:0]);
    run(2);
    rd(4, s); chk(s == 2, "R8 full match pass", 128'(s), 2);
    rx = e ^ (128'hff << (120 - 8 * 12));
    setup(8, 16, 0); wr(1, 10);
    wr(10, rx[127:64]); wr(11, rx[63:0]);
    run(2);
    rd(4, s); chk(s == 2, "R8 diff beyond len pass", 128'(s), 2);
    rx = e ^ (128'h01 << (120 - 8 * 9));
    setup(8, 16, 0);
    wr(10, rx[127:64]); wr(11, rx[63:0]);
    run(2);
    rd(4, s); chk(s == 4, "R8 diff inside len fail", 128'(s), 4);
    wr(1, 16);
  endtask

  task automatic t_icv_len();
    logic [63:0] d;
    wait_idle();
    wr(1, 9);  rd(1, d); chk(d == 16, "R9 odd length ignored", 128'(d), 16);
    wr(1, 6);  rd(1, d); chk(d == 16, "R9 short length ignored", 128'(d), 16);
    wr(1, 18); rd(1, d); chk(d == 16, "R9 long length ignored", 128'(d), 16);
    wr(1, 14); rd(1, d); chk(d == 14, "R9 legal length taken", 128'(d), 14);
    wr(1, 8);  rd(1, d); chk(d == 8, "R9 minimum length taken", 128'(d), 8);
    wr(1, 16);
  endtask

  task automatic t_busy_writes();
    logic [63:0] d;
    setup(0, 16, 0);
    send(msg[0]);
    wait_idle();
    wr(3, 0);
    wr(0, 64'hf);  // must be dropped
    while (busy) @(negedge clk);
    rd(0, d); chk(d == 0, "R11 write while busy ignored", 128'(d), 0);
    rd(12, d); chk(d == 64'(fe(0) >> 64), "R12 ctx5 address", 128'(d), fe(0) >> 64);
  endtask

  initial begin
    for (int i = 0; i < 8; i++)
      msg[i] = {32'(i * 32'h9e3779b9), 32'hdead0000 + 32'(i), 32'(i * 32'h7f4a7c15), 32'hc0de0000 ^ 32'(i)};
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full();
    t_partial_final();
    t_reuse();
    t_suspend();
    t_icv();
    t_icv_len();
    t_busy_writes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL R11 watchdog expired act=1 exp=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule